// File: doc/BRIEF.md
# Password Guard for a Protected Command Set

This block keeps a 64-bit password as four 16-bit words and acts on bus cycles that an upstream mode sequencer has already decoded, while that sequencer reports the password command set as active. Each word is programmed with its own two-cycle command. Each word reads back with a single read cycle. A fixed seven-cycle unlock sequence presents all four words between an opening pair of cycles and a closing cycle. The `unlocked` flag rises only when every presented word matches the stored one.

Bus cycles arrive on a valid/ready stream. A cycle is taken on a rising clock edge where `cyc_valid` and `cyc_ready` are both high. Each taken read cycle produces one response on a second valid/ready stream. A response stays on `rd_data` with `rd_valid` high until a clock edge where `rd_ready` is high. While a response waits, `cyc_ready` is low, so the upstream side must hold its cycle. Nothing is dropped. The `cmd_active` and `unlocked` pins are plain level signals.

Top module: `pwd_guard`

## Requirements
- R1: After reset, `unlocked` is 0, `rd_valid` is 0, and all four words read back as 16'hFFFF.
- R2: A taken write with data 16'h00A0 at any address, followed by a taken write at address k (0 to 3), stores that data in word k. The other words are left unchanged.
- R3: A read at address 0 to 3 returns word k on `rd_data` in the cycle after it is taken. A read at an address with any bit above bit 1 set returns 16'h0000.
- R4: If the second write of a program command has an address with any bit above bit 1 set, no word is changed.
- R5: The unlock sequence consists of these taken writes, in this order:
  - data 16'h0025 at address 0;
  - data 16'h0003 at address 0;
  - the four stored words at addresses 0, 1, 2 and 3;
  - data 16'h0029 at address 0.
  When every word matches, `unlocked` is 1 from the clock edge that takes the last write.
- R6: If any presented word differs from the stored word, `unlocked` is 0 after the last write, even if it was 1 before. Outside that last write, `unlocked` does not change.
- R7: The unlock sequence is aborted by any of these: a wrong code, a wrong address, a read cycle, or `cmd_active` going low. After an abort, the remaining cycles of the broken sequence leave `unlocked` unchanged. A fresh sequence still works.
- R8: While `cmd_active` is 0, write cycles change no word.
- R9: While `rd_valid` is 1 and `rd_ready` is 0, `cyc_ready` is 0 and `rd_data` holds its value.
- R10: When no command is pending, a write whose data is neither 16'h00A0 nor 16'h0025-at-address-0 has no effect on the words or on `unlocked`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_active | input | 1 | Password command set is active |
| cyc_valid | input | 1 | A bus cycle is offered |
| cyc_ready | output | 1 | The offered cycle can be taken |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cyc_addr | input | 8 | Word address of the cycle |
| cyc_data | input | 16 | Write data |
| rd_valid | output | 1 | A read response is present |
| rd_ready | input | 1 | The consumer takes the response |
| rd_data | output | 16 | Read response data |
| unlocked | output | 1 | The password has been presented correctly |

## Verification
The bench builds the block with its default parameters:
- 16-bit words;
- four words;
- an 8-bit address.

With these values the address bits above the word index are easy to reach. Addresses such as 0x04 and 0x80 exercise the full-range decode for reads and for programming. Four words also make the step from the last word index into the closing cycle short enough to test directly, both with matching and with mismatching words. The mode flag and the read back-pressure path are driven by hand, so an abort and a held response can each be observed cycle by cycle.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_CODE,
    ST_WORDS,
    ST_END
  } seq_st_t;
endpackage

// File: rtl/pwd_store.sv
module pwd_store #(
  parameter int WORD_W = 16,
  parameter int NUM_WORDS = 4,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [WORD_W-1:0] w_data,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic              r_in_range,
  output logic [WORD_W-1:0] r_data,
  input  logic [IDX_W-1:0]  c_idx,
  input  logic [WORD_W-1:0] c_data,
  output logic              c_eq
);
  logic [WORD_W-1:0] mem [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[i] <= '1;
      else if (we && w_idx == IDX_W'(i)) mem[i] <= w_data;
    end

    // R2
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && w_idx == IDX_W'(i)) |=> $stable(mem[i]));
  end

  always_comb begin
    r_data = r_in_range ? mem[r_idx] : '0;
    c_eq   = (mem[c_idx] == c_data);
  end
endmodule

// File: rtl/pwd_seq.sv
module pwd_seq
  import pwd_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int NUM_WORDS = 4,
  parameter logic [WORD_W-1:0] CMD_PROG  = 'h00A0,
  parameter logic [WORD_W-1:0] CMD_OPEN  = 'h0025,
  parameter logic [WORD_W-1:0] CMD_COUNT = 'h0003,
  parameter logic [WORD_W-1:0] CMD_CLOSE = 'h0029,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              acc,
  input  logic              is_wr,
  input  logic              addr_zero,
  input  logic              in_range,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] data,
  input  logic              cmp_eq,
  output logic              we,
  output logic [IDX_W-1:0]  cmp_idx,
  output logic              unlocked
);
  seq_st_t          st;
  logic [IDX_W-1:0] k;
  logic             ok;
  logic             wr_take;

  assign wr_take = active && acc && is_wr;
  assign we      = wr_take && st == ST_PROG && in_range;
  assign cmp_idx = k;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      k        <= '0;
      ok       <= 1'b0;
      unlocked <= 1'b0;
    end else if (!active) begin
      st <= ST_IDLE;
    end else if (acc && !is_wr) begin
      st <= ST_IDLE;
    end else if (wr_take) begin
      case (st)
        ST_IDLE: begin
          if (data == CMD_PROG) st <= ST_PROG;
          else if (data == CMD_OPEN && addr_zero) st <= ST_CODE;
        end
        ST_PROG: st <= ST_IDLE;
        ST_CODE: begin
          if (data == CMD_COUNT && addr_zero) begin
            st <= ST_WORDS;
            k  <= '0;
            ok <= 1'b1;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_WORDS: begin
          if (in_range && idx == k) begin
            ok <= ok && cmp_eq;
            if (k == IDX_W'(NUM_WORDS - 1)) st <= ST_END;
            else k <= k + 1'b1;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_END: begin
          st <= ST_IDLE;
          if (data == CMD_CLOSE && addr_zero) unlocked <= ok;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5
  unlock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(st) == ST_END);

  // R6
  unlock_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked != $past(unlocked)) |-> ($past(st) == ST_END && $past(wr_take)));

  // R7
  read_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !is_wr) |=> st == ST_IDLE);
endmodule

// File: rtl/pwd_rsp.sv
module pwd_rsp #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WORD_W-1:0] data_in,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (take) begin
      rd_valid <= 1'b1;
      rd_data  <= data_in;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R9
  no_take_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && rd_valid && !rd_ready));
endmodule

// File: rtl/pwd_guard.sv
module pwd_guard #(
  parameter int WORD_W = 16,
  parameter int NUM_WORDS = 4,
  parameter int ADDR_W = 8,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_active,
  input  logic              cyc_valid,
  output logic              cyc_ready,
  input  logic              cyc_write,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [WORD_W-1:0] cyc_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic              unlocked
);
  logic              acc;
  logic              in_range;
  logic              addr_zero;
  logic [IDX_W-1:0]  idx;
  logic              we;
  logic [IDX_W-1:0]  cmp_idx;
  logic              cmp_eq;
  logic [WORD_W-1:0] r_word;

  assign cyc_ready = !rd_valid || rd_ready;
  assign acc       = cyc_valid && cyc_ready;
  assign idx       = cyc_addr[IDX_W-1:0];
  assign in_range  = (cyc_addr[ADDR_W-1:IDX_W] == '0);
  assign addr_zero = (cyc_addr == '0);

  pwd_store #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(we), .w_idx(idx), .w_data(cyc_data),
    .r_idx(idx), .r_in_range(in_range), .r_data(r_word),
    .c_idx(cmp_idx), .c_data(cyc_data), .c_eq(cmp_eq)
  );

  pwd_seq #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .active(cmd_active), .acc(acc),
    .is_wr(cyc_write), .addr_zero(addr_zero), .in_range(in_range),
    .idx(idx), .data(cyc_data), .cmp_eq(cmp_eq),
    .we(we), .cmp_idx(cmp_idx), .unlocked(unlocked)
  );

  pwd_rsp #(.WORD_W(WORD_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .take(acc && !cyc_write),
    .data_in(r_word), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: tb/tb_pwd_guard.sv
module tb_pwd_guard;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_active = 1;
  logic        cyc_valid = 0;
  logic        cyc_ready;
  logic        cyc_write = 0;
  logic [7:0]  cyc_addr = '0;
  logic [15:0] cyc_data = '0;
  logic        rd_valid;
  logic        rd_ready = 1;
  logic [15:0] rd_data;
  logic        unlocked;

  int checks = 0;
  int fails = 0;
  logic [15:0] expw [4];

  pwd_guard dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_take();
    while (!cyc_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cyc_valid = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    cyc_valid = 1; cyc_write = 1; cyc_addr = a; cyc_data = d;
    wait_take();
  endtask

  task automatic rd(string req, logic [7:0] a, logic [15:0] exp);
    @(negedge clk);
    cyc_valid = 1; cyc_write = 0; cyc_addr = a;
    wait_take();
    chk(req, {31'd0, rd_valid}, 32'd1);
    chk(req, {16'd0, rd_data}, {16'd0, exp});
  endtask

  task automatic prog(logic [7:0] a, logic [15:0] d);
    wr(8'h33, 16'h00A0);
    wr(a, d);
  endtask

  task automatic unlock_seq(logic [15:0] w0, logic [15:0] w1,
                            logic [15:0] w2, logic [15:0] w3);
    wr(8'h00, 16'h0025);
    wr(8'h00, 16'h0003);
    wr(8'h00, w0);
    wr(8'h01, w1);
    wr(8'h02, w2);
    wr(8'h03, w3);
  endtask

  task automatic t_reset();
    chk("R1 unlocked", {31'd0, unlocked}, 0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 0);
    for (int i = 0; i < 4; i++) rd("R1 word", 8'(i), 16'hFFFF);
  endtask

  task automatic t_program();
    expw[0] = 16'h1111; expw[1] = 16'h2222; expw[2] = 16'h3333; expw[3] = 16'h4444;
    prog(8'h02, expw[2]);
    rd("R2 word2", 8'h02, expw[2]);
    rd("R2 word0 untouched", 8'h00, 16'hFFFF);
    prog(8'h00, expw[0]);
    prog(8'h03, expw[3]);
    prog(8'h01, expw[1]);
    for (int i = 0; i < 4; i++) rd("R2 R3 readback", 8'(i), expw[i]);
  endtask

  task automatic t_range();
    rd("R3 addr 04", 8'h04, 16'h0000);
    rd("R3 addr 81", 8'h81, 16'h0000);
    prog(8'h41, 16'hDEAD);
    rd("R4 word1 kept", 8'h01, expw[1]);
    rd("R4 alias read", 8'h41, 16'h0000);
  endtask

  task automatic t_ignored();
    wr(8'h01, 16'h5555);
    wr(8'h02, 16'h0029);
    wr(8'h05, 16'h0025);
    wr(8'h00, 16'h0003);
    wr(8'h00, 16'h0029);
    chk("R10 unlocked", {31'd0, unlocked}, 0);
    for (int i = 0; i < 4; i++) rd("R10 words", 8'(i), expw[i]);
  endtask

  task automatic t_inactive();
    cmd_active = 0;
    prog(8'h01, 16'hBEEF);
    cmd_active = 1;
    rd("R8 word1 kept", 8'h01, expw[1]);
    wr(8'h00, 16'h0025);
    wr(8'h00, 16'h0003);
    cmd_active = 0;
    @(negedge clk);
    cmd_active = 1;
    wr(8'h00, expw[0]); wr(8'h01, expw[1]); wr(8'h02, expw[2]); wr(8'h03, expw[3]);
    wr(8'h00, 16'h0029);
    chk("R7 inactive abort", {31'd0, unlocked}, 0);
  endtask

  task automatic t_abort();
    wr(8'h00, 16'h0025); wr(8'h00, 16'h0003);
    wr(8'h00, expw[0]); wr(8'h01, expw[1]);
    rd("R7 read midway", 8'h03, expw[3]);
    wr(8'h02, expw[2]); wr(8'h03, expw[3]);
    wr(8'h00, 16'h0029);
    chk("R7 read abort", {31'd0, unlocked}, 0);
    wr(8'h00, 16'h0025); wr(8'h00, 16'h0003);
    wr(8'h00, expw[0]); wr(8'h02, expw[2]);
    wr(8'h02, expw[2]); wr(8'h03, expw[3]); wr(8'h00, 16'h0029);
    chk("R7 address abort", {31'd0, unlocked}, 0);
  endtask

  task automatic t_mismatch(string req, logic exp_before);
    unlock_seq(expw[0], expw[1], 16'h3334, expw[3]);
    chk(req, {31'd0, unlocked}, {31'd0, exp_before});
    wr(8'h00, 16'h0029);
    chk(req, {31'd0, unlocked}, 0);
  endtask

  task automatic t_unlock_ok();
    unlock_seq(expw[0], expw[1], expw[2], expw[3]);
    chk("R5 before close", {31'd0, unlocked}, 0);
    wr(8'h00, 16'h0029);
    chk("R5 unlocked", {31'd0, unlocked}, 1);
    wr(8'h01, 16'h0029);
    rd("R6 read keeps flag", 8'h00, expw[0]);
    chk("R6 flag held", {31'd0, unlocked}, 1);
  endtask

  task automatic t_backpressure();
    rd_ready = 0;
    @(negedge clk);
    cyc_valid = 1; cyc_write = 0; cyc_addr = 8'h02;
    wait_take();
    chk("R9 valid", {31'd0, rd_valid}, 1);
    chk("R9 data", {16'd0, rd_data}, {16'd0, expw[2]});
    chk("R9 ready low", {31'd0, cyc_ready}, 0);
    cyc_valid = 1; cyc_write = 0; cyc_addr = 8'h03;
    repeat (3) @(negedge clk);
    chk("R9 held data", {16'd0, rd_data}, {16'd0, expw[2]});
    chk("R9 still stalled", {31'd0, cyc_ready}, 0);
    rd_ready = 1;
    @(negedge clk);
    chk("R9 next taken", {16'd0, rd_data}, {16'd0, expw[3]});
    cyc_valid = 0;
    @(negedge clk);
    chk("R9 drained", {31'd0, rd_valid}, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_program();
    t_range();
    t_ignored();
    t_inactive();
    t_mismatch("R6 mismatch low", 1'b0);
    t_abort();
    t_unlock_ok();
    t_mismatch("R6 mismatch clears", 1'b1);
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule